// File: doc/BRIEF.md
# Programmed-I/O Byte FIFO with Command Capture

This block is the byte queue that a host uses to move data through one register address. A write strobe pushes a byte and a read strobe pops one. Both act in a single clock cycle. The block tracks how many bytes it holds with a read position, a write position and an occupancy count. It refuses a write one slot before the storage is full and records that overrun in a sticky flag. A pop while the bus is in the data-out phase yields zero instead of stored data. A pop that empties the queue brings both positions back to the first slot.

A capture flag sends host writes to a separate command buffer instead of the queue. That buffer holds the bytes of a command descriptor and counts them. A response-load strobe replaces the queue contents with a two-byte completion response: a status byte, then a zero byte. A flush strobe sets the interrupt reason to function-complete and clears the flag register and the overrun flag. Every successful pop and every response load produce a one-cycle interrupt-request pulse.

Top module: `dfifo_cmd_capture`

## Requirements
- R1: After reset, occupancy, read data, overrun, command length, interrupt pulse, interrupt reason and flag register are all zero.
- R2: While `capture_en` is high, a write stores its byte in the command buffer at index `cmd_len` and increments `cmd_len`, and the FIFO occupancy does not change. `cmd_len` restarts from 0 on the cycle `capture_en` goes from low to high, so a write in that cycle lands at index 0.
- R3: The command buffer holds `CMD_DEPTH` (32) bytes. When it is full, further capture writes are ignored and `cmd_len` and the buffer contents stay as they are.
- R4: Outside capture mode, a write when occupancy is below `DEPTH-1` stores the byte at the tail and increments occupancy. A write at occupancy `DEPTH-1` (15) is dropped and sets the sticky `overrun` flag.
- R5: A read when occupancy is nonzero pops bytes in the order they were written. `reg_rdata` shows the byte from the cycle after the strobe, occupancy decrements, and `irq` is high for exactly that one cycle.
- R6: A read when occupancy is zero changes nothing: `reg_rdata` keeps its previous value and no `irq` pulse is produced.
- R7: A pop while `phase` equals 3'b000 (data-out) puts 8'h00 on `reg_rdata` and decrements occupancy, but the read position does not advance. The next pop in another phase returns the byte that the zeroed pop skipped.
- R8: When a pop brings occupancy to zero, the read and write positions both return to slot 0, so the next write is the next byte read.
- R9: `rsp_load` discards the queue contents. The queue then holds `rsp_status` followed by 8'h00, occupancy becomes 2, `flag_bits` becomes 8'h02, and `irq` pulses in the following cycle.
- R10: `flush` sets `int_reason` to 8'h08 (function complete) and clears `flag_bits` and `overrun`. Occupancy and queue contents are unchanged. A same-cycle `rsp_load` still sets `flag_bits` to 2, and a same-cycle dropped write still sets `overrun`.
- R11: When strobes coincide, `rsp_load` takes precedence over `reg_rd`, and `reg_rd` takes precedence over `reg_wr`. The strobe that loses has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Host write strobe to the FIFO register |
| reg_rd | input | 1 | Host read strobe from the FIFO register |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | FIFO output register (last popped byte) |
| capture_en | input | 1 | Route writes to the command buffer |
| phase | input | 3 | Current bus phase; 3'b000 is data-out |
| rsp_load | input | 1 | Load the two-byte completion response |
| rsp_status | input | 8 | Status byte for the response |
| flush | input | 1 | Flush command strobe |
| irq | output | 1 | One-cycle interrupt request |
| fifo_count | output | 5 | Occupancy |
| overrun | output | 1 | Sticky overrun flag |
| cmd_len | output | 6 | Bytes held in the command buffer |
| cmd_idx | input | 5 | Command buffer read index |
| cmd_byte | output | 8 | Command buffer byte at `cmd_idx` |
| int_reason | output | 8 | Interrupt reason register |
| flag_bits | output | 8 | Flag register |

## Verification
The hardest state to reach is a mismatch between the read and write positions that a zeroed data-out pop leaves behind. It only matters if the queue then drains and is refilled, so that the position reset of R8 decides which byte comes out. Directed sequences build this case: they write two bytes, pop them in the data-out phase, write again, and pop in a data phase. The random phase of the test draws data-out pops often enough to repeat the pattern at many occupancies. That phase also fills the queue to the overrun point and runs the command buffer past 32 bytes.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;

    localparam logic [7:0] REASON_FUNC_DONE = 8'h08;
    localparam logic [7:0] RSP_FLAG_VALUE   = 8'h02;
    localparam logic [2:0] PHASE_DATA_OUT   = 3'b000;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_LOAD_RSP,
        OP_POP,
        OP_EMPTY_READ,
        OP_PUSH,
        OP_DROP_OVR,
        OP_CAPTURE,
        OP_DROP_CMD
    } fifo_op_e;

endpackage

// File: rtl/dfifo_store.sv
module dfifo_store #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [W-1:0]     wr_data,
    input  logic             preset_en,
    input  logic [W-1:0]     preset_byte,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic [W-1:0]     rd_data
);

    logic [W-1:0] slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [W-1:0] slot_d;
        always_comb begin
            slot_d = slot_q[i];
            if (preset_en) begin
                if (i == 0) begin
                    slot_d = preset_byte;
                end else if (i == 1) begin
                    slot_d = '0;
                end
            end else if (wr_en && (wr_ptr == PTR_W'(i))) begin
                slot_d = wr_data;
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else begin
                slot_q[i] <= slot_d;
            end
        end
    end

    assign rd_data = slot_q[rd_ptr];

endmodule

// File: rtl/dfifo_cmdbuf.sv
module dfifo_cmdbuf #(
    parameter int DEPTH = 32,
    parameter int W     = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data
);

    logic [W-1:0] byte_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_byte
        logic [W-1:0] byte_d;
        always_comb begin
            byte_d = byte_q[i];
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                byte_d = wr_data;
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q[i] <= '0;
            end else begin
                byte_q[i] <= byte_d;
            end
        end
    end

    assign rd_data = byte_q[rd_idx];

endmodule

// File: rtl/dfifo_cmd_capture.sv
module dfifo_cmd_capture
    import dfifo_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int CMD_DEPTH = 32,
    parameter int W         = 8,
    localparam int PTR_W    = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int CIDX_W   = $clog2(CMD_DEPTH),
    localparam int CLEN_W   = $clog2(CMD_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    input  logic              capture_en,
    input  logic [2:0]        phase,
    input  logic              rsp_load,
    input  logic [W-1:0]      rsp_status,
    input  logic              flush,
    output logic              irq,
    output logic [CNT_W-1:0]  fifo_count,
    output logic              overrun,
    output logic [CLEN_W-1:0] cmd_len,
    input  logic [CIDX_W-1:0] cmd_idx,
    output logic [W-1:0]      cmd_byte,
    output logic [7:0]        int_reason,
    output logic [7:0]        flag_bits
);

    typedef struct packed {
        logic [PTR_W-1:0]  rptr;
        logic [PTR_W-1:0]  wptr;
        logic [CNT_W-1:0]  count;
        logic [W-1:0]      rdata;
        logic              overrun;
        logic [CLEN_W-1:0] cmd_len;
        logic              cap_prev;
        logic              irq;
        logic [7:0]        reason;
        logic [7:0]        flags;
    } state_t;

    localparam logic [CNT_W-1:0]  COUNT_LIMIT = CNT_W'(DEPTH - 1);
    localparam logic [CLEN_W-1:0] CMD_FULL    = CLEN_W'(CMD_DEPTH);

    state_t   state_q, state_d;
    fifo_op_e op;

    logic              cap_start;
    logic [CLEN_W-1:0] cmd_len_eff;
    logic [W-1:0]      head_byte;
    logic              store_wr;
    logic              cmd_wr;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Classify the single operation performed this cycle.
    always_comb begin
        cap_start   = capture_en && !state_q.cap_prev;
        cmd_len_eff = cap_start ? '0 : state_q.cmd_len;
        op          = OP_NONE;
        if (rsp_load) begin
            op = OP_LOAD_RSP;
        end else if (reg_rd) begin
            op = (state_q.count != '0) ? OP_POP : OP_EMPTY_READ;
        end else if (reg_wr) begin
            if (capture_en) begin
                op = (cmd_len_eff < CMD_FULL) ? OP_CAPTURE : OP_DROP_CMD;
            end else begin
                op = (state_q.count == COUNT_LIMIT) ? OP_DROP_OVR : OP_PUSH;
            end
        end
    end

    // Next-state computation.
    always_comb begin
        state_d          = state_q;
        state_d.irq      = 1'b0;
        state_d.cap_prev = capture_en;
        state_d.cmd_len  = cmd_len_eff;
        store_wr         = 1'b0;
        cmd_wr           = 1'b0;

        if (flush) begin
            state_d.reason  = REASON_FUNC_DONE;
            state_d.flags   = '0;
            state_d.overrun = 1'b0;
        end

        unique case (op)
            OP_LOAD_RSP: begin
                state_d.rptr  = '0;
                state_d.wptr  = PTR_W'(2);
                state_d.count = CNT_W'(2);
                state_d.flags = RSP_FLAG_VALUE;
                state_d.irq   = 1'b1;
            end
            OP_POP: begin
                state_d.count = state_q.count - 1'b1;
                state_d.irq   = 1'b1;
                if (phase == PHASE_DATA_OUT) begin
                    state_d.rdata = '0;
                end else begin
                    state_d.rdata = head_byte;
                    state_d.rptr  = ptr_inc(state_q.rptr);
                end
                if (state_q.count == CNT_W'(1)) begin
                    state_d.rptr = '0;
                    state_d.wptr = '0;
                end
            end
            OP_PUSH: begin
                store_wr      = 1'b1;
                state_d.wptr  = ptr_inc(state_q.wptr);
                state_d.count = state_q.count + 1'b1;
            end
            OP_DROP_OVR: begin
                state_d.overrun = 1'b1;
            end
            OP_CAPTURE: begin
                cmd_wr          = 1'b1;
                state_d.cmd_len = cmd_len_eff + 1'b1;
            end
            OP_EMPTY_READ, OP_DROP_CMD, OP_NONE: begin
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    dfifo_store #(
        .DEPTH (DEPTH),
        .W     (W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (store_wr),
        .wr_ptr      (state_q.wptr),
        .wr_data     (reg_wdata),
        .preset_en   (rsp_load),
        .preset_byte (rsp_status),
        .rd_ptr      (state_q.rptr),
        .rd_data     (head_byte)
    );

    dfifo_cmdbuf #(
        .DEPTH (CMD_DEPTH),
        .W     (W)
    ) u_cmdbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cmd_wr),
        .wr_idx  (cmd_len_eff[CIDX_W-1:0]),
        .wr_data (reg_wdata),
        .rd_idx  (cmd_idx),
        .rd_data (cmd_byte)
    );

    assign reg_rdata  = state_q.rdata;
    assign irq        = state_q.irq;
    assign fifo_count = state_q.count;
    assign overrun    = state_q.overrun;
    assign cmd_len    = state_q.cmd_len;
    assign int_reason = state_q.reason;
    assign flag_bits  = state_q.flags;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= COUNT_LIMIT); // R4
    AST_CMD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_len <= CMD_FULL); // R3
    AST_EMPTY_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count == '0) |-> (state_q.rptr == '0 && state_q.wptr == '0)); // R8
    AST_POP_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !rsp_load && fifo_count != '0) |=> irq); // R5
    AST_NO_SPURIOUS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!rsp_load && !(reg_rd && fifo_count != '0)) |=> !irq); // R6
    AST_CAPTURE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && capture_en && !reg_rd && !rsp_load) |=> $stable(fifo_count)); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !capture_en && !reg_rd && !rsp_load && fifo_count == COUNT_LIMIT)
        |=> (overrun && fifo_count == COUNT_LIMIT)); // R4
    AST_RSP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_load |=> (fifo_count == CNT_W'(2) && flag_bits == RSP_FLAG_VALUE && irq)); // R9

endmodule

// File: tb/dfifo_cmd_capture_tb.sv
`timescale 1ns/1ps
module dfifo_cmd_capture_tb;

    localparam int DEPTH = 16;
    localparam int CMD_DEPTH = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0, capture_en = 1'b0, rsp_load = 1'b0, flush = 1'b0;
    logic [7:0] reg_wdata = '0, rsp_status = '0;
    logic [2:0] phase = 3'b001;
    logic [4:0] cmd_idx = '0;
    logic [7:0] reg_rdata, cmd_byte, int_reason, flag_bits;
    logic       irq, overrun;
    logic [4:0] fifo_count;
    logic [5:0] cmd_len;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench expectation state
    logic [7:0] m_mem [DEPTH];
    logic [7:0] m_cmd [CMD_DEPTH];
    int m_rp, m_wp, m_cnt, m_clen;
    logic [7:0] m_rdata, m_reason, m_flags;
    bit m_ovr, m_irq, m_capq;

    always #2.5 clk = ~clk;

    dfifo_cmd_capture u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .capture_en(capture_en),
        .phase(phase), .rsp_load(rsp_load), .rsp_status(rsp_status), .flush(flush),
        .irq(irq), .fifo_count(fifo_count), .overrun(overrun), .cmd_len(cmd_len),
        .cmd_idx(cmd_idx), .cmd_byte(cmd_byte), .int_reason(int_reason),
        .flag_bits(flag_bits)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int pinc(input int p);
        return (p == DEPTH - 1) ? 0 : p + 1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        for (int i = 0; i < CMD_DEPTH; i++) m_cmd[i] = '0;
        m_rp = 0; m_wp = 0; m_cnt = 0; m_clen = 0;
        m_rdata = '0; m_reason = '0; m_flags = '0;
        m_ovr = 0; m_irq = 0; m_capq = 0;
    endtask

    // expected effect of one cycle, per R2..R11
    task automatic model_step(input bit wr, input bit rd, input logic [7:0] wd, input bit cap,
                              input logic [2:0] ph, input bit rl, input logic [7:0] st, input bit fl);
        int clen_eff;
        clen_eff = (cap && !m_capq) ? 0 : m_clen;
        m_capq = cap;
        m_clen = clen_eff;
        m_irq = 0;
        if (fl) begin
            m_reason = 8'h08; m_flags = 8'h00; m_ovr = 0;
        end
        if (rl) begin
            m_mem[0] = st; m_mem[1] = 8'h00;
            m_rp = 0; m_wp = 2; m_cnt = 2; m_flags = 8'h02; m_irq = 1;
        end else if (rd) begin
            if (m_cnt != 0) begin
                m_irq = 1;
                if (ph == 3'b000) m_rdata = 8'h00;
                else begin
                    m_rdata = m_mem[m_rp];
                    m_rp = pinc(m_rp);
                end
                m_cnt--;
                if (m_cnt == 0) begin m_rp = 0; m_wp = 0; end
            end
        end else if (wr) begin
            if (cap) begin
                if (clen_eff < CMD_DEPTH) begin
                    m_cmd[clen_eff] = wd;
                    m_clen = clen_eff + 1;
                end
            end else if (m_cnt == DEPTH - 1) begin
                m_ovr = 1;
            end else begin
                m_mem[m_wp] = wd;
                m_wp = pinc(m_wp);
                m_cnt++;
            end
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "fifo_count", int'(fifo_count), m_cnt);
        chk(tag, "reg_rdata", int'(reg_rdata), int'(m_rdata));
        chk(tag, "irq", int'(irq), int'(m_irq));
        chk(tag, "overrun", int'(overrun), int'(m_ovr));
        chk(tag, "cmd_len", int'(cmd_len), m_clen);
        chk(tag, "int_reason", int'(int_reason), int'(m_reason));
        chk(tag, "flag_bits", int'(flag_bits), int'(m_flags));
        cmd_idx = 5'($urandom_range(0, CMD_DEPTH - 1));
        #0.1;
        chk(tag, "cmd_byte", int'(cmd_byte), int'(m_cmd[cmd_idx]));
    endtask

    // called at a negedge; returns at the next negedge after checking
    task automatic cyc(input string tag, input bit wr, input bit rd, input logic [7:0] wd,
                       input bit cap, input logic [2:0] ph, input bit rl,
                       input logic [7:0] st, input bit fl);
        reg_wr = wr; reg_rd = rd; reg_wdata = wd; capture_en = cap; phase = ph;
        rsp_load = rl; rsp_status = st; flush = fl;
        model_step(wr, rd, wd, cap, ph, rl, st, fl);
        @(posedge clk);
        @(negedge clk);
        reg_wr = 0; reg_rd = 0; rsp_load = 0; flush = 0;
        check_all(tag);
    endtask

    task automatic wr_b(input string tag, input logic [7:0] d, input bit cap);
        cyc(tag, 1, 0, d, cap, 3'b001, 0, 8'h00, 0);
    endtask

    task automatic rd_b(input string tag, input logic [2:0] ph);
        cyc(tag, 0, 1, 8'h00, 0, ph, 0, 8'h00, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R4: fill to the limit, then one more write overruns
        for (int i = 0; i < DEPTH - 1; i++) wr_b("R4", 8'(8'h10 + i), 0);
        wr_b("R4", 8'hEE, 0);
        // R10: flush clears overrun, keeps contents
        cyc("R10", 0, 0, 8'h00, 0, 3'b001, 0, 8'h00, 1);
        // R5: drain in order; R8 at the end
        for (int i = 0; i < DEPTH - 1; i++) rd_b("R5", 3'b001);
        // R6: empty read keeps value, no irq
        rd_b("R6", 3'b001);
        // R7: data-out pop yields zero, does not advance
        wr_b("R7", 8'hA1, 0);
        wr_b("R7", 8'hB2, 0);
        rd_b("R7", 3'b000);
        rd_b("R7", 3'b010);
        // R8: drain by data-out pops, refill, next byte read is the new one
        wr_b("R8", 8'hC3, 0);
        rd_b("R8", 3'b000);
        wr_b("R8", 8'hD4, 0);
        rd_b("R8", 3'b011);
        // R9: response load
        wr_b("R9", 8'h77, 0);
        cyc("R9", 0, 0, 8'h00, 0, 3'b001, 1, 8'h5A, 0);
        rd_b("R9", 3'b001);
        rd_b("R9", 3'b001);
        // R10 with same-cycle response load
        cyc("R10", 0, 0, 8'h00, 0, 3'b001, 1, 8'h33, 1);
        // R11: coinciding strobes
        cyc("R11", 1, 1, 8'h99, 0, 3'b001, 0, 8'h00, 0);
        cyc("R11", 1, 1, 8'h98, 0, 3'b001, 1, 8'h44, 0);
        // R2, R3: capture, overfill command buffer
        for (int i = 0; i < CMD_DEPTH + 2; i++) wr_b("R3", 8'(8'h40 + i), 1);
        cyc("R2", 0, 0, 8'h00, 0, 3'b001, 0, 8'h00, 0);
        wr_b("R2", 8'hF0, 1);
        wr_b("R2", 8'hF1, 1);
        cyc("R2", 0, 0, 8'h00, 0, 3'b001, 0, 8'h00, 0);

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            int sel;
            bit wr, rd, rl, fl, cap;
            logic [2:0] ph;
            sel = int'($urandom_range(0, 99));
            wr = 0; rd = 0; rl = 0;
            if (sel < 45) wr = 1;
            else if (sel < 85) rd = 1;
            else if (sel < 88) rl = 1;
            else if (sel < 90) begin wr = 1; rd = 1; end
            fl = ($urandom_range(0, 19) == 0);
            cap = ((n / 64) % 4 == 3);
            ph = ($urandom_range(0, 3) == 0) ? 3'b000 : 3'($urandom_range(1, 7));
            cyc("R11", wr, rd, 8'($urandom), cap, ph, rl, 8'($urandom), fl);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule